// File: doc/BRIEF.md
# Legacy-Mode Interrupt Aggregator

This block gathers a small set of device interrupt lines into three 32-bit registers (an enable mask, a line-level mirror and a latched event set) and drives one interrupt request toward the processor. Each device reports a line change as a one-cycle notification together with the new line state. A change sets the device's event bit, and the event set is then filtered through the mask. Software reads the three registers and writes the mask and a clear register. Every value crosses the bus with its byte lanes reversed.

Only the legacy emulation mode is handled. It is turned on by the top bit of the mask register. While that bit is clear, line changes are dropped. Writes to the mask and clear registers still take effect.

Top module: `irq_legacy_agg`

## Requirements
- R1: After reset the mask, levels and events registers read zero and `cpu_irq` is low.
- R2: Bus data is the register value with its bytes reversed: bus bits 7:0 carry register bits 31:24, bus bits 15:8 carry register bits 23:16, bus bits 23:16 carry register bits 15:8, and bus bits 31:24 carry register bits 7:0. This holds for both reads and writes.
- R3: Source input 0 maps to register bit 18, source input 1 to bit 12, and source input 2 to bit 19.
- R4: While bit 31 (the mode bit) of the mask register, as held before the edge, is 0, line changes leave events and levels unchanged.
- R5: A line change in mode sets the source's bit in events, and then events is ANDed with the mask held before the edge. Several sources may change in the same cycle.
- R6: On a line change in mode, the source's levels bit takes the reported line state: 1 sets it and 0 clears it.
- R7: `cpu_irq` is a register. It is high from the edge at which events becomes nonzero and stays high until the edge at which events returns to zero.
- R8: A write with `wr_sel`=1 (clear register) whose register-order value has bit 31 set zeroes events.
- R9: A clear write whose register-order value has bit 31 clear ANDs events with that value.
- R10: When a clear write and a line change fall in the same cycle, the clear is applied first and the line-change update is then applied to the result.
- R11: A write with `wr_sel`=0 loads the mask at the next edge. A line change in the same cycle uses the previous mask, both for its mode test and for its AND.
- R12: `rd_sel` selects the read value combinationally: 0 selects the mask, 1 the levels, 2 the events, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_chg | input | 3 | One-cycle line-change notification, one bit per source |
| src_lvl | input | 3 | New line state for each source, used when its `src_chg` bit is set |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mask, 1 clear |
| wr_data | input | 32 | Write data in bus byte order |
| rd_sel | input | 2 | Read select: 0 mask, 1 levels, 2 events, 3 zero |
| rd_data | output | 32 | Read data in bus byte order |
| cpu_irq | output | 1 | Registered processor interrupt request |

## Verification
Each mask, levels or events update is due at the first rising edge after the stimulus, and `rd_data` shows it combinationally after that edge. `cpu_irq` is computed from the next event set, so it changes on the same edge as events and not one cycle later. The bench drives stimulus on the falling edge and advances its reference model at the following rising edge. It then steps `rd_sel` through all four codes within that same cycle, comparing every read and `cpu_irq` a nanosecond after the edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W       = 32;
    localparam int MAX_SRC     = 3;
    localparam int MODE_BIT    = 31;
    localparam int CLR_ALL_BIT = 31;

    // register bit position of each source input
    localparam int SRC_POS [MAX_SRC] = '{18, 12, 19};

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [1:0] {
        RD_MASK   = 2'd0,
        RD_LEVELS = 2'd1,
        RD_EVENTS = 2'd2,
        RD_NONE   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        reg_t mask;
        reg_t levels;
        reg_t events;
        logic irq;
    } agg_state_t;

    // bus order <-> register order (self-inverse)
    function automatic reg_t lane_swap(reg_t v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] src_chg,
    input  logic [NSRC-1:0] src_lvl,
    output reg_t            chg_bits,
    output reg_t            rise_bits,
    output reg_t            fall_bits
);

    reg_t chg_one  [NSRC];
    reg_t rise_one [NSRC];
    reg_t fall_one [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int POS = SRC_POS[i];
        always_comb begin
            chg_one[i]       = '0;
            rise_one[i]      = '0;
            fall_one[i]      = '0;
            chg_one[i][POS]  = src_chg[i];
            rise_one[i][POS] = src_chg[i] & src_lvl[i];
            fall_one[i][POS] = src_chg[i] & ~src_lvl[i];
        end
    end

    always_comb begin
        chg_bits  = '0;
        rise_bits = '0;
        fall_bits = '0;
        for (int i = 0; i < NSRC; i++) begin
            chg_bits  = chg_bits  | chg_one[i];
            rise_bits = rise_bits | rise_one[i];
            fall_bits = fall_bits | fall_one[i];
        end
    end

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_agg_pkg::*;
(
    input  logic       wr_en,
    input  logic       wr_sel,
    input  reg_t       wr_data,
    input  logic [1:0] rd_sel,
    input  reg_t       mask_q,
    input  reg_t       levels_q,
    input  reg_t       events_q,
    output logic       mask_wr,
    output logic       clr_wr,
    output reg_t       wr_val,
    output reg_t       rd_data
);

    reg_t rd_reg;

    always_comb begin
        mask_wr = wr_en & ~wr_sel;
        clr_wr  = wr_en & wr_sel;
        wr_val  = lane_swap(wr_data);
    end

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            RD_MASK:   rd_reg = mask_q;
            RD_LEVELS: rd_reg = levels_q;
            RD_EVENTS: rd_reg = events_q;
            default:   rd_reg = '0;
        endcase
        rd_data = lane_swap(rd_reg);
    end

endmodule

// File: rtl/irq_core.sv
module irq_core
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic clr_wr,
    input  reg_t wr_val,
    input  reg_t chg_bits,
    input  reg_t rise_bits,
    input  reg_t fall_bits,
    output reg_t mask_q,
    output reg_t levels_q,
    output reg_t events_q,
    output logic irq_q
);

    agg_state_t st_d, st_q;
    reg_t       ev_c;
    logic       mode_on;
    logic       any_chg;

    always_comb begin
        mode_on = st_q.mask[MODE_BIT];
        any_chg = |chg_bits;
        st_d    = st_q;
        if (mask_wr) st_d.mask = wr_val;
        // clear first
        ev_c = st_q.events;
        if (clr_wr) begin
            if (wr_val[CLR_ALL_BIT]) ev_c = '0;
            else                     ev_c = ev_c & wr_val;
        end
        // then line changes, filtered by the mask held before this edge
        if (mode_on && any_chg) begin
            ev_c        = (ev_c | chg_bits) & st_q.mask;
            st_d.levels = (st_q.levels | rise_bits) & ~fall_bits;
        end
        st_d.events = ev_c;
        st_d.irq    = |ev_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q   = st_q.mask;
    assign levels_q = st_q.levels;
    assign events_q = st_q.events;
    assign irq_q    = st_q.irq;

    AST_IRQ_FOLLOWS_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (events_q != '0)); // R7
    AST_IDLE_OUT_OF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[MODE_BIT] && !clr_wr) |=> $stable(events_q) && $stable(levels_q)); // R4
    AST_EVENTS_INSIDE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[MODE_BIT] && (chg_bits != '0)) |=> ((events_q & ~$past(mask_q)) == '0)); // R5
    AST_CLEAR_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wr_val[CLR_ALL_BIT] && (chg_bits == '0)) |=> (events_q == '0)); // R8
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wr_val))); // R11
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q)); // R11

endmodule

// File: rtl/irq_legacy_agg.sv
module irq_legacy_agg
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_chg,
    input  logic [NSRC-1:0] src_lvl,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      rd_sel,
    output logic [31:0]     rd_data,
    output logic            cpu_irq
);

    reg_t chg_bits, rise_bits, fall_bits;
    reg_t mask_q, levels_q, events_q, wr_val;
    logic mask_wr, clr_wr;

    irq_src_map #(.NSRC(NSRC)) u_map (
        .src_chg   (src_chg),
        .src_lvl   (src_lvl),
        .chg_bits  (chg_bits),
        .rise_bits (rise_bits),
        .fall_bits (fall_bits)
    );

    irq_bus_port u_port (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .mask_q   (mask_q),
        .levels_q (levels_q),
        .events_q (events_q),
        .mask_wr  (mask_wr),
        .clr_wr   (clr_wr),
        .wr_val   (wr_val),
        .rd_data  (rd_data)
    );

    irq_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (mask_wr),
        .clr_wr    (clr_wr),
        .wr_val    (wr_val),
        .chg_bits  (chg_bits),
        .rise_bits (rise_bits),
        .fall_bits (fall_bits),
        .mask_q    (mask_q),
        .levels_q  (levels_q),
        .events_q  (events_q),
        .irq_q     (cpu_irq)
    );

endmodule

// File: tb/irq_legacy_agg_bench.sv
module irq_legacy_agg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_chg = '0;
    logic [2:0]  src_lvl = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state, register order
    logic [31:0] m_mask = '0, m_lev = '0, m_ev = '0;
    logic        m_irq = 1'b0;
    int          pos [3] = '{18, 12, 19};

    always #5 clk = ~clk;

    irq_legacy_agg u_irq_legacy_agg (
        .clk(clk), .rst_n(rst_n), .src_chg(src_chg), .src_lvl(src_lvl),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] flip(logic [31:0] v);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = v[8*(3-k) +: 8];
        return r;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        for (int r = 0; r < 4; r++) begin
            rd_sel = r[1:0];
            #1;
            case (r)
                0: check(req, "mask read",   rd_data, flip(m_mask));
                1: check(req, "levels read", rd_data, flip(m_lev));
                2: check(req, "events read", rd_data, flip(m_ev));
                default: check("R12", "select 3 read", rd_data, 32'h0);
            endcase
        end
        check(req, "cpu_irq", {31'd0, cpu_irq}, {31'd0, m_irq});
    endtask

    // one clock: drive at falling edge, model at rising edge, compare after it
    task automatic cycle(string req, logic [2:0] chg, logic [2:0] lvl,
                         logic wen, logic wsel, logic [31:0] wbus);
        logic [31:0] ev, v, nmask;
        @(negedge clk);
        src_chg = chg; src_lvl = lvl; wr_en = wen; wr_sel = wsel; wr_data = wbus;
        @(posedge clk);
        nmask = m_mask;
        if (wen && !wsel) nmask = flip(wbus);
        ev = m_ev;
        if (wen && wsel) begin
            v = flip(wbus);
            if (v[31]) ev = 32'h0;
            else       ev = ev & v;
        end
        if (m_mask[31] && chg != 3'b000) begin
            for (int i = 0; i < 3; i++)
                if (chg[i]) begin
                    ev[pos[i]]    = 1'b1;
                    m_lev[pos[i]] = lvl[i];
                end
            ev = ev & m_mask;
        end
        m_mask = nmask;
        m_ev   = ev;
        m_irq  = (ev != 32'h0);
        #1;
        compare_all(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        // R4: mode off, change ignored
        cycle("R4", 3'b001, 3'b001, 0, 0, 32'h0);
        // R2 R11: enable mode with bits 19,18,12
        cycle("R11", 3'b000, 3'b000, 1, 0, flip(32'h800C_1000));
        check("R2", "raw bus mask", flip(32'h800C_1000), 32'h0010_0C80);
        // R3 R5 R6 R7: source 0 goes high
        cycle("R3", 3'b001, 3'b001, 0, 0, 32'h0);
        // R5: two sources in one cycle
        cycle("R5", 3'b110, 3'b110, 0, 0, 32'h0);
        // R6: source 0 falls, event stays
        cycle("R6", 3'b001, 3'b000, 0, 0, 32'h0);
        // R9: AND-clear removes bit 18
        cycle("R9", 3'b000, 3'b000, 1, 1, flip(~32'h8004_0000));
        // mask without bit 19, then a change filters events
        cycle("R11", 3'b000, 3'b000, 1, 0, flip(32'h8004_1000));
        cycle("R5", 3'b010, 3'b001, 0, 0, 32'h0);
        // R8 R7: clear all, irq drops
        cycle("R8", 3'b000, 3'b000, 1, 1, flip(32'h8000_0000));
        cycle("R7", 3'b000, 3'b000, 0, 0, 32'h0);
        // R10: clear-all and change together, new event survives
        cycle("R10", 3'b010, 3'b000, 0, 0, 32'h0);
        cycle("R10", 3'b001, 3'b001, 1, 1, flip(32'h8000_0000));
        // R10: AND-clear with zero and change together
        cycle("R10", 3'b010, 3'b001, 1, 1, 32'h0);
        // R11: mask write and change in same cycle uses old mask
        cycle("R11", 3'b100, 3'b001, 1, 0, flip(32'h800C_1000));
        cycle("R11", 3'b100, 3'b001, 0, 0, 32'h0);
        // R4: mode off while events pending, changes ignored
        cycle("R4", 3'b000, 3'b000, 1, 0, flip(32'h000C_1000));
        cycle("R4", 3'b111, 3'b000, 0, 0, 32'h0);
        cycle("R9", 3'b000, 3'b000, 1, 1, flip(32'h0008_0000));
        cycle("R8", 3'b000, 3'b000, 1, 1, flip(32'hFFFF_FFFF));
        cycle("R7", 3'b000, 3'b000, 0, 0, 32'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule